// File: doc/BRIEF.md
# Sixteen-Channel Serial Interrupt Collector

This block folds the interrupt requests of sixteen serial channels into a single level-sensitive host interrupt. Each channel drives one raw request bit, held high for as long as that channel needs service. The host sees the raw requests in a read-only status word. It picks which channels may interrupt through an inhibit word, in which a set bit blocks its channel. A master enable bit sits in a third word and gates the output line as a whole.

After an interrupt the host reads the pending word, which holds the requests that pass the inhibit word, and services those channels in any order it likes. Requests are cleared at the channels themselves. Nothing is acknowledged here, so the line drops once the last unblocked request goes away. Reset blocks every channel and turns the master enable off, so the line stays quiet until software opens it.

The register port is a plain word-addressed port. A write takes effect on the clock edge that samples it. A read is combinational from the address.

Top module: `sia_irq_aggregator`

## Requirements
- R1: Word address 0 (status) reads the sixteen raw requests in bits 15:0, with channel n in bit n, and zeros in bits 31:16. It follows the requests in the same cycle.
- R2: Word address 1 (inhibit) reads back the last value written to its bits 15:0. A set bit n blocks channel n from the pending word and the interrupt. A clear bit lets it through.
- R3: While reset is asserted and after it is released, the inhibit word reads 0x0000FFFF, the enable word reads zero and the interrupt output is low.
- R4: Word address 2 (enable) holds the master enable in bit 20 and reads zero in every other bit. While the enable is clear, the interrupt output stays low whatever the requests and the inhibit word are.
- R5: On each clock edge the interrupt output takes the value (enable AND any bit of (requests AND NOT inhibit)) that holds at that edge. It is a level, so it stays high as long as that condition stays true.
- R6: Word address 3 (pending) reads the requests AND NOT inhibit in bits 15:0 and zeros above. It follows the requests in the same cycle.
- R7: Reading any word address from 4 to 15 returns zero. Writing any of them changes neither the inhibit word nor the enable.
- R8: Writing the status or pending address changes neither the inhibit word nor the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | 16 | Raw request level per channel |
| reg_addr_i | input | 4 | Word address for reads and writes |
| reg_wr_i | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Level interrupt to the host, registered |

## Verification
The design keeps only two pieces of state, the inhibit word and the enable bit. Either one going wrong shows up on reg_rdata_o in the very cycle after the faulty edge, as long as that register is addressed. It also shows up on irq_o one edge later, as soon as a request arrives on a channel whose blocking state differs from the reference. The bench therefore compares both the read data and the interrupt line every cycle, while it sweeps the address and the requests. A wrong decode shows up as a non-zero read at an unmapped address, or as a register that changes after a write to some other address.

// File: rtl/sia_pkg.sv
package sia_pkg;
    localparam int NUM_CH  = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int GEN_BIT = 20;

    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_INHIB  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_ENABLE = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] ADR_PEND   = ADDR_W'(3);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_INHIB,
        SEL_ENABLE,
        SEL_PEND
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        unique case (a)
            ADR_STATUS: s = SEL_STATUS;
            ADR_INHIB:  s = SEL_INHIB;
            ADR_ENABLE: s = SEL_ENABLE;
            ADR_PEND:   s = SEL_PEND;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/sia_chan_gate.sv
module sia_chan_gate #(
    parameter int NUM_CH = sia_pkg::NUM_CH
) (
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] inhib_i,
    output logic [NUM_CH-1:0] pend_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        assign pend_o[g] = req_i[g] & ~inhib_i[g];
    end
endmodule

// File: rtl/sia_regs.sv
module sia_regs
    import sia_pkg::*;
#(
    parameter int NUM_CH  = sia_pkg::NUM_CH,
    parameter int DATA_W  = sia_pkg::DATA_W,
    parameter int ADDR_W  = sia_pkg::ADDR_W,
    parameter int GEN_BIT = sia_pkg::GEN_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [NUM_CH-1:0] req_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic [NUM_CH-1:0] inhib_o,
    output logic              gen_en_o,
    output logic [DATA_W-1:0] rdata_o
);
    reg_sel_e          sel;
    logic [NUM_CH-1:0] inhib_q;
    logic              en_q;

    assign sel = reg_sel_e'(decode_addr(addr_i));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inhib_q <= '1;
            en_q    <= 1'b0;
        end else if (wr_i) begin
            unique case (sel)
                SEL_INHIB:  inhib_q <= wdata_i[NUM_CH-1:0];
                SEL_ENABLE: en_q    <= wdata_i[GEN_BIT];
                default:    ;
            endcase
        end
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_STATUS: rdata_o[NUM_CH-1:0] = req_i;
            SEL_INHIB:  rdata_o[NUM_CH-1:0] = inhib_q;
            SEL_ENABLE: rdata_o[GEN_BIT]    = en_q;
            SEL_PEND:   rdata_o[NUM_CH-1:0] = pend_i;
            default:    ;
        endcase
    end

    assign inhib_o  = inhib_q;
    assign gen_en_o = en_q;

    AST_INHIB_RESET_ALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (inhib_q == '1 && !en_q)); // R3
    AST_UNMAPPED_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel == SEL_NONE) |=> ($stable(inhib_q) && $stable(en_q))); // R7
    AST_RO_WR_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (sel == SEL_STATUS || sel == SEL_PEND)) |=> ($stable(inhib_q) && $stable(en_q))); // R8
endmodule

// File: rtl/sia_irq_drive.sv
module sia_irq_drive #(
    parameter int NUM_CH = sia_pkg::NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gen_en_i,
    input  logic [NUM_CH-1:0] pend_i,
    output logic              irq_o
);
    logic irq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= gen_en_i & (|pend_i);
    end

    assign irq_o = irq_q;

    AST_GEN_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en_i |=> !irq_q); // R4
    AST_NO_PEND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |=> !irq_q); // R5
    AST_PEND_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_en_i && pend_i != '0) |=> irq_q); // R5
endmodule

// File: rtl/sia_irq_aggregator.sv
module sia_irq_aggregator
    import sia_pkg::*;
#(
    parameter int NUM_CH  = sia_pkg::NUM_CH,
    parameter int DATA_W  = sia_pkg::DATA_W,
    parameter int ADDR_W  = sia_pkg::ADDR_W,
    parameter int GEN_BIT = sia_pkg::GEN_BIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_req_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0] inhib;
    logic [NUM_CH-1:0] pend;
    logic              gen_en;

    sia_chan_gate #(.NUM_CH(NUM_CH)) i_gate (
        .req_i   (chan_req_i),
        .inhib_i (inhib),
        .pend_o  (pend)
    );

    sia_regs #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .GEN_BIT(GEN_BIT)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr_i   (reg_addr_i),
        .wr_i     (reg_wr_i),
        .wdata_i  (reg_wdata_i),
        .req_i    (chan_req_i),
        .pend_i   (pend),
        .inhib_o  (inhib),
        .gen_en_o (gen_en),
        .rdata_o  (reg_rdata_o)
    );

    sia_irq_drive #(.NUM_CH(NUM_CH)) i_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .gen_en_i (gen_en),
        .pend_i   (pend),
        .irq_o    (irq_o)
    );
endmodule

// File: tb/test_sia_irq_aggregator.sv
`timescale 1ns/1ps
module test_sia_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic [3:0]  addr = 4'd1;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_vec = 0;
    int n_bad = 0;
    int cyc_cnt = 0;

    logic [15:0] mdl_inhib = 16'hFFFF;
    logic        mdl_en = 1'b0;
    logic        mdl_irq = 1'b0;

    always #4 clk = ~clk;

    sia_irq_aggregator i_sia_irq_aggregator (
        .clk(clk), .rst_n(rst_n), .chan_req_i(req), .reg_addr_i(addr),
        .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdl_inhib <= 16'hFFFF;
            mdl_en    <= 1'b0;
            mdl_irq   <= 1'b0;
        end else begin
            mdl_irq <= mdl_en && ((req & ~mdl_inhib) != 16'h0);
            if (wr && addr == 4'd1) mdl_inhib <= wdata[15:0];
            if (wr && addr == 4'd2) mdl_en    <= wdata[20];
        end
    end

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        case (a)
            4'd0:    return {16'h0, req};
            4'd1:    return {16'h0, mdl_inhib};
            4'd2:    return mdl_en ? 32'h0010_0000 : 32'h0;
            4'd3:    return {16'h0, req & ~mdl_inhib};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string read_tag(input logic [3:0] a);
        if (!rst_n) return "R3";
        case (a)
            4'd0:    return "R1";
            4'd1:    return "R2";
            4'd2:    return "R4";
            4'd3:    return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        check(rst_n ? "R5" : "R3", {31'h0, irq}, {31'h0, mdl_irq});
        check(read_tag(addr), rdata, exp_read(addr));
    end

    task automatic step(input logic [15:0] r, input logic [3:0] a,
                        input logic w, input logic [31:0] d);
        @(posedge clk);
        #2;
        req = r; addr = a; wr = w; wdata = d;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R3", rdata, 32'h0000_FFFF);
        check("R3", {31'h0, irq}, 32'h0);
        rst_n = 1'b1;
        step(16'h0, 4'd1, 1'b0, 32'h0);
        #2 check("R3", rdata, 32'h0000_FFFF);
        step(16'h0, 4'd2, 1'b0, 32'h0);
        #2 check("R3", rdata, 32'h0);
        step(16'h00F0, 4'd0, 1'b0, 32'h0);
        #2 check("R1", rdata, 32'h0000_00F0);
        // enable with junk in other bits; all channels still blocked
        step(16'h00F0, 4'd2, 1'b1, 32'hFFEF_FFFF);
        step(16'h00F0, 4'd2, 1'b1, 32'hFFFF_FFFF);
        step(16'h00F0, 4'd2, 1'b0, 32'h0);
        #2 check("R4", rdata, 32'h0010_0000);
        step(16'h00F0, 4'd3, 1'b0, 32'h0);
        #2 check("R2", {31'h0, irq}, 32'h0);
        // unblock channel 5 only
        step(16'h00F0, 4'd1, 1'b1, 32'h0000_FFDF);
        step(16'h00F0, 4'd3, 1'b0, 32'h0);
        #2 check("R6", rdata, 32'h0000_0020);
        step(16'h00F0, 4'd3, 1'b0, 32'h0);
        #2 check("R5", {31'h0, irq}, 32'h1);
        // request on a blocked channel only
        step(16'h0001, 4'd3, 1'b0, 32'h0);
        step(16'h0001, 4'd3, 1'b0, 32'h0);
        #2 check("R2", {31'h0, irq}, 32'h0);
        // master enable off with open channel requesting
        step(16'h0020, 4'd2, 1'b1, 32'h0);
        step(16'h0020, 4'd2, 1'b0, 32'h0);
        step(16'h0020, 4'd2, 1'b0, 32'h0);
        #2 check("R4", {31'h0, irq}, 32'h0);
        // writes to read-only and unmapped words
        step(16'h0020, 4'd0, 1'b1, 32'hFFFF_FFFF);
        step(16'h0020, 4'd3, 1'b1, 32'hFFFF_FFFF);
        step(16'h0020, 4'd1, 1'b0, 32'h0);
        #2 check("R8", rdata, 32'h0000_FFDF);
        for (int a = 4; a < 16; a++) step(16'h0020, 4'(a), 1'b1, 32'hFFFF_FFFF);
        step(16'h0020, 4'd2, 1'b0, 32'h0);
        #2 check("R7", rdata, 32'h0);
        step(16'h0020, 4'd9, 1'b0, 32'h0);
        #2 check("R7", rdata, 32'h0);
        for (int i = 0; i < 400; i++)
            step(16'($urandom), 4'($urandom_range(0, 7)), 1'($urandom),
                 ($urandom_range(0, 1) == 1) ? 32'h0010_0000 | 32'($urandom & 32'h0000_0F0F) : 32'($urandom));
        step(16'h0, 4'd0, 1'b0, 32'h0);
        repeat (2) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 20000) begin
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cyc_cnt);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule